// File: doc/BRIEF.md
# Hardware Loop Replay Buffer

This block sits between instruction fetch and the decoder. Outside a loop it is a wire: fetched words pass straight to the decoder, and the decoder's ready goes back to fetch. A loop-start word carries two counts. One is the number of words that form the loop's control expression and the other is the number of words in the loop body. The block keeps the sum of the two as the loop length.

After a loop-start word, the block stores that many following words as they arrive from fetch, and forwards each one to the decoder as it stores it. When the last word has been accepted, it stops fetch, raises a hold on the program counter and replays the stored words in a ring. The program counter stays frozen for the whole replay, so the decoder gets the loop again and again with no jump bubble.

An external exit signal is examined each time the final stored word is issued. When that signal is high at that point, the block gives a one-cycle redirect carrying the address just past the loop, releases the hold and goes back to pass-through. A flush input drops any capture or replay at once.

Top module: `loop_replay_buffer`

## Requirements
- R1: Outside capture and replay, d_valid equals f_valid, d_word equals f_word, f_ready equals d_ready, and pc_hold is low.
- R2: A word whose bits [31:24] are 0xF0 is a loop-start. Bits [15:8] give the control count and bits [7:0] give the body count. The total is their 9-bit sum. The loop-start word itself is forwarded to the decoder like any other word.
- R3: A loop-start whose total is zero, or larger than DEPTH, starts no capture: pass-through continues and pc_hold stays low.
- R4: A loop-start accepted with a valid total makes the next `total` accepted fetch words both forwarded to the decoder and stored. Each word is forwarded in the cycle it is accepted.
- R5: In the cycle after the last captured word is accepted, replay begins. While replay lasts, pc_hold is high and f_ready is low.
- R6: Replay presents the stored words in capture order, starting from the first. It moves to the next word only on a cycle with d_ready high. While d_ready is low, d_valid stays high and d_word stays stable.
- R7: loop_exit is examined only when the last stored word is accepted by the decoder. If it is high, pc_redirect pulses for that cycle, pc_target equals the loop-start address + 1 + total, and the block returns to pass-through on the next cycle. If it is low, replay wraps to the first word. At any other time loop_exit has no effect.
- R8: A loop-start word that arrives during capture, or that is replayed, is treated as an ordinary word and starts no nested capture.
- R9: While flush is high, d_valid, f_ready, pc_hold and pc_redirect are low and nothing is stored. On the following cycle the block is in pass-through.
- R10: During and right after reset, the block is in pass-through, with pc_hold and pc_redirect low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop any loop state now |
| f_valid | input | 1 | Fetch word valid |
| f_ready | output | 1 | Block accepts the fetch word |
| f_word | input | W | Fetched instruction word |
| f_pc | input | AW | Address of the fetched word |
| d_valid | output | 1 | Word valid toward decoder |
| d_ready | input | 1 | Decoder accepts the word |
| d_word | output | W | Word toward decoder |
| loop_exit | input | 1 | Loop exit condition met |
| pc_hold | output | 1 | Program counter frozen (replay active) |
| pc_redirect | output | 1 | One-cycle pulse: resume fetch at pc_target |
| pc_target | output | AW | Address just past the loop |

## Verification
The bench builds the block with DEPTH set to 8. With that capacity, a loop of exactly eight words and a rejected nine-word loop both fit in short test programs, so both sides of the capacity limit get exercised. The test program also holds zero-length loops, count pairs whose 8-bit sum carries into a ninth bit, and a loop-start placed inside a loop body. Random handshake stalls, exit pulses and flushes reach the replay wrap, backpressure on the final word, and a flush in the middle of a capture.

// File: rtl/loop_rb_pkg.sv
package loop_rb_pkg;

    typedef enum logic [1:0] {
        LB_PASS   = 2'd0,
        LB_FILL   = 2'd1,
        LB_REPLAY = 2'd2
    } lb_mode_e;

endpackage

// File: rtl/loop_start_decode.sv
module loop_start_decode #(
    parameter int W     = 32,
    parameter int CNT_W = 8,
    parameter int OPC_W = 8,
    parameter logic [OPC_W-1:0] OPC = 8'hF0,
    parameter int DEPTH = 32
) (
    input  logic [W-1:0]     word,
    output logic             is_start,
    output logic [CNT_W:0]   total,
    output logic             fits
);
    localparam int TOT_W = CNT_W + 1;

    logic [CNT_W-1:0] ctl_cnt;
    logic [CNT_W-1:0] body_cnt;

    assign is_start = (word[W-1 -: OPC_W] == OPC);
    assign ctl_cnt  = word[2*CNT_W-1 -: CNT_W];
    assign body_cnt = word[CNT_W-1:0];
    assign total    = {1'b0, ctl_cnt} + {1'b0, body_cnt};
    assign fits     = (total != '0) && (total <= TOT_W'(DEPTH));

endmodule

// File: rtl/loop_ring_store.sv
module loop_ring_store #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slots[waddr] <= wdata;
    end

    assign rdata = slots[raddr];

endmodule

// File: rtl/loop_replay_buffer.sv
module loop_replay_buffer
    import loop_rb_pkg::*;
#(
    parameter int W     = 32,
    parameter int AW    = 16,
    parameter int DEPTH = 32,
    parameter int CNT_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          f_valid,
    output logic          f_ready,
    input  logic [W-1:0]  f_word,
    input  logic [AW-1:0] f_pc,
    output logic          d_valid,
    input  logic          d_ready,
    output logic [W-1:0]  d_word,
    input  logic          loop_exit,
    output logic          pc_hold,
    output logic          pc_redirect,
    output logic [AW-1:0] pc_target
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LEN_W = $clog2(DEPTH + 1);

    typedef struct packed {
        lb_mode_e         mode;
        logic [LEN_W-1:0] len;
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [AW-1:0]    base;
    } lb_state_t;

    lb_state_t st_q, st_d;

    logic             is_start;
    logic [CNT_W:0]   total;
    logic             fits;
    logic             we;
    logic [W-1:0]     rdata;
    logic             accept;
    logic             w_last;
    logic             r_last;

    loop_start_decode #(
        .W(W), .CNT_W(CNT_W), .OPC_W(8), .OPC(8'hF0), .DEPTH(DEPTH)
    ) i_dec (
        .word(f_word), .is_start(is_start), .total(total), .fits(fits)
    );

    loop_ring_store #(
        .W(W), .DEPTH(DEPTH)
    ) i_store (
        .clk(clk), .we(we), .waddr(st_q.wptr), .wdata(f_word),
        .raddr(st_q.rptr), .rdata(rdata)
    );

    assign accept    = f_valid && d_ready;
    assign w_last    = (LEN_W'(st_q.wptr) == st_q.len - LEN_W'(1));
    assign r_last    = (LEN_W'(st_q.rptr) == st_q.len - LEN_W'(1));
    assign pc_target = st_q.base + AW'(1) + AW'(st_q.len);

    always_comb begin
        st_d        = st_q;
        d_valid     = 1'b0;
        d_word      = f_word;
        f_ready     = 1'b0;
        pc_hold     = 1'b0;
        pc_redirect = 1'b0;
        we          = 1'b0;
        unique case (st_q.mode)
            LB_PASS: begin
                d_valid = f_valid;
                f_ready = d_ready;
                if (accept && is_start && fits) begin
                    st_d.mode = LB_FILL;
                    st_d.len  = LEN_W'(total);
                    st_d.wptr = '0;
                    st_d.base = f_pc;
                end
            end
            LB_FILL: begin
                d_valid = f_valid;
                f_ready = d_ready;
                if (accept) begin
                    we = 1'b1;
                    if (w_last) begin
                        st_d.mode = LB_REPLAY;
                        st_d.rptr = '0;
                    end else begin
                        st_d.wptr = st_q.wptr + PTR_W'(1);
                    end
                end
            end
            LB_REPLAY: begin
                d_valid = 1'b1;
                d_word  = rdata;
                pc_hold = 1'b1;
                if (d_ready) begin
                    if (r_last) begin
                        if (loop_exit) begin
                            pc_redirect = 1'b1;
                            st_d.mode   = LB_PASS;
                        end else begin
                            st_d.rptr = '0;
                        end
                    end else begin
                        st_d.rptr = st_q.rptr + PTR_W'(1);
                    end
                end
            end
            default: st_d.mode = LB_PASS;
        endcase
        if (flush) begin
            d_valid     = 1'b0;
            f_ready     = 1'b0;
            pc_hold     = 1'b0;
            pc_redirect = 1'b0;
            we          = 1'b0;
            st_d.mode   = LB_PASS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: LB_PASS, len: '0, wptr: '0, rptr: '0, base: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/loop_replay_checker.sv
module loop_replay_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         flush,
    input logic         f_valid,
    input logic         f_ready,
    input logic         d_valid,
    input logic         d_ready,
    input logic [W-1:0] d_word,
    input logic         loop_exit,
    input logic         pc_hold,
    input logic         pc_redirect
);
    a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_hold && !flush) |-> (f_ready == d_ready && d_valid == f_valid));

    a_r5_hold_blocks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (!f_ready && d_valid));

    a_r6_stall_keeps_word: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (pc_hold && !d_ready) |=> (pc_hold && d_valid && $stable(d_word)));

    a_r7_redirect_cause: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redirect |-> (pc_hold && loop_exit && d_ready));

    a_r7_redirect_releases: assert property (@(posedge clk) disable iff (!rst_n || flush)
        pc_redirect |=> !pc_hold);

    a_r9_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!d_valid && !f_ready && !pc_hold && !pc_redirect));

    a_r9_flush_releases: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pc_hold);

endmodule

bind loop_replay_buffer loop_replay_checker #(.W(W)) i_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .f_valid(f_valid),
    .f_ready(f_ready), .d_valid(d_valid), .d_ready(d_ready), .d_word(d_word),
    .loop_exit(loop_exit), .pc_hold(pc_hold), .pc_redirect(pc_redirect)
);

// File: tb/test_loop_replay_buffer.sv
module test_loop_replay_buffer;
    localparam int W     = 32;
    localparam int AW    = 16;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          f_valid = 1'b0;
    logic          f_ready;
    logic [W-1:0]  f_word = '0;
    logic [AW-1:0] f_pc = '0;
    logic          d_valid;
    logic          d_ready = 1'b0;
    logic [W-1:0]  d_word;
    logic          loop_exit = 1'b0;
    logic          pc_hold;
    logic          pc_redirect;
    logic [AW-1:0] pc_target;

    always #2 clk = ~clk;

    loop_replay_buffer #(.W(W), .AW(AW), .DEPTH(DEPTH), .CNT_W(8)) i_loop_replay_buffer (
        .clk(clk), .rst_n(rst_n), .flush(flush), .f_valid(f_valid), .f_ready(f_ready),
        .f_word(f_word), .f_pc(f_pc), .d_valid(d_valid), .d_ready(d_ready),
        .d_word(d_word), .loop_exit(loop_exit), .pc_hold(pc_hold),
        .pc_redirect(pc_redirect), .pc_target(pc_target)
    );

    int total = 0;
    int bad   = 0;
    logic [W-1:0] prog [256];

    // model state: 0 pass, 1 capture, 2 replay
    int           m_mode = 0;
    int           m_len  = 0;
    int           m_idx  = 0;
    int           m_base = 0;
    logic [W-1:0] m_buf [$];
    int           pc = 0;

    function automatic logic [W-1:0] mk(input int c, input int b);
        return {8'hF0, 8'h00, 8'(c), 8'(b)};
    endfunction

    function automatic bit is_st(input logic [W-1:0] w);
        return w[31:24] == 8'hF0;
    endfunction

    function automatic int tot_of(input logic [W-1:0] w);
        return int'(w[15:8]) + int'(w[7:0]);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h at %0t", tag, what, got, exp, $time);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) prog[i] = 32'h0100_0000 | i;
        prog[5]   = mk(1, 3);     // total 4
        prog[20]  = mk(0, 0);     // zero, no-op
        prog[30]  = mk(4, 5);     // 9 > DEPTH, no-op
        prog[40]  = mk(3, 5);     // exactly DEPTH
        prog[43]  = mk(0, 2);     // loop-start inside body
        prog[60]  = mk(2, 0);     // control only
        prog[80]  = mk(0, 1);     // single word loop
        prog[120] = mk(255, 255); // 9-bit sum, too large
        prog[140] = mk(128, 128); // sum 256, too large

        // R10: reset state
        repeat (3) begin
            @(negedge clk);
            #1;
            chk("R10", "d_valid", 32'(d_valid), 32'd0);
            chk("R10", "pc_hold", 32'(pc_hold), 32'd0);
            chk("R10", "pc_redirect", 32'(pc_redirect), 32'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10", "pc_hold after reset", 32'(pc_hold), 32'd0);

        for (int cyc = 0; cyc < 4000; cyc++) begin
            bit fv, dr, ex, fl, e_dv, e_fr, e_hold, e_redir;
            logic [W-1:0] e_dw;
            string tag;
            int e_tgt;
            if (cyc > 0) @(negedge clk);
            fv = (cyc < 400) ? 1'b1 : ($urandom_range(99) < 80);
            dr = (cyc < 400) ? 1'b1 : ($urandom_range(99) < 75);
            ex = ($urandom_range(99) < 35);
            fl = (cyc >= 2000) && ($urandom_range(99) < 3);
            f_valid   = fv;
            d_ready   = dr;
            loop_exit = ex;
            flush     = fl;
            f_word    = prog[pc % 256];
            f_pc      = AW'(pc);
            #1;
            e_redir = 1'b0;
            e_tgt   = (m_base + 1 + m_len) % 65536;
            if (m_mode == 2) begin
                e_dv = 1'b1; e_dw = m_buf[m_idx]; e_fr = 1'b0; e_hold = 1'b1;
                tag = is_st(e_dw) ? "R8" : "R6";
            end else begin
                e_dv = fv; e_dw = f_word; e_fr = dr; e_hold = 1'b0;
                if (m_mode == 1) tag = is_st(f_word) ? "R8" : "R4";
                else if (is_st(f_word))
                    tag = (tot_of(f_word) >= 1 && tot_of(f_word) <= DEPTH) ? "R2" : "R3";
                else tag = "R1";
            end
            if (fl) begin
                e_dv = 1'b0; e_fr = 1'b0; e_hold = 1'b0; tag = "R9";
            end
            chk(tag, "d_valid", 32'(d_valid), 32'(e_dv));
            if (e_dv) chk(tag, "d_word", d_word, e_dw);
            chk(tag, "f_ready", 32'(f_ready), 32'(e_fr));
            chk((m_mode == 2 && !fl) ? "R5" : tag, "pc_hold", 32'(pc_hold), 32'(e_hold));

            // model update
            if (fl) begin
                m_mode = 0;
            end else if (m_mode == 2) begin
                if (dr) begin
                    if (m_idx == m_len - 1) begin
                        if (ex) begin
                            e_redir = 1'b1;
                            m_mode  = 0;
                        end else m_idx = 0;
                    end else m_idx++;
                end
            end else if (fv && dr) begin
                if (m_mode == 1) begin
                    m_buf.push_back(f_word);
                    if (m_buf.size() == m_len) begin
                        m_mode = 2;
                        m_idx  = 0;
                    end
                end else if (is_st(f_word) && tot_of(f_word) >= 1 && tot_of(f_word) <= DEPTH) begin
                    m_mode = 1;
                    m_len  = tot_of(f_word);
                    m_base = pc;
                    m_buf.delete();
                end
                pc++;
            end
            chk("R7", "pc_redirect", 32'(pc_redirect), 32'(e_redir));
            if (e_redir) begin
                chk("R7", "pc_target", 32'(pc_target), 32'(e_tgt));
                pc = e_tgt;
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule